// File: doc/BRIEF.md
# Bit-Serial Transmit Framer with Request-to-Send Control

The block drives the transmit side of a bit-serial controller. Each frame goes out as a synchronization preamble taken from a programmable pattern register, followed by the frame's data bytes shifted out most-significant bit first. Every register in the block advances only on a bit-clock enable, so one serial bit lasts from one enable pulse to the next. An upstream source supplies bytes through a valid/ready handshake and marks the first and the last byte of each frame.

Between frames the line carries one of two fills, picked by a fill-mode input. In idle fill the line rests at logic 1 and request-to-send is low; request-to-send rises one bit ahead of a frame and falls after the frame's last data bit. In sync fill the sync pattern repeats back to back, and request-to-send stays high for as long as the block is enabled. The fill mode, the preamble length and the enable may change at any time. The block samples them only at a frame or pattern boundary, so a frame already on the line always finishes as it started.

Top module: `sfr_tx_framer`

## Requirements
- R1: While reset is held and right after it, `txd` is 1, `rts` is 0 and `in_ready` is 0.
- R2: The preamble is the low part of `sync_pat`, sent from the highest bit of that part down to bit 0. The width comes from `sync_len`: 2'b01 gives bits [3:0], 2'b10 gives bits [7:0], 2'b11 gives bits [15:0], and 2'b00 sends no preamble.
- R3: Data bytes follow the preamble with no gap, each sent MSB first. The bytes of one frame go out back to back.
- R4: `in_ready` is high for exactly one bit time in each of these places: during the last preamble bit; during the lead bit when there is no preamble; and during the last bit of each byte not flagged `in_last`. A byte is taken on a bit-clock enable that finds `in_ready` and `in_valid` both high.
- R5: If `in_valid` is low in a bit time where `in_ready` is high, the frame ends after the current bit, as if the previous byte had been the last.
- R6: With `fill_sync` = 0, the line is 1 and `rts` is 0 between frames. A frame opens with one lead bit of 1 that has `rts` high, and `rts` returns to 0 in the bit right after the last data bit.
- R7: With `fill_sync` = 1 and a nonzero `sync_len`, the sync pattern repeats between frames. A frame waits for the end of the current pattern and then sends a full preamble. `rts` stays 1 while the block is enabled. With `sync_len` = 2'b00 the fill is 1 and `rts` is also held at 1.
- R8: `fill_sync`, `sync_len` and `enable` are sampled only at a frame or pattern boundary. A change made in the middle of a frame or a fill pattern leaves that frame or pattern unchanged.
- R9: With `enable` low at a boundary, no frame starts, `txd` stays 1, `rts` stays 0 and `in_ready` stays 0.
- R10: A clock cycle with `bit_en` low changes none of `txd`, `rts` or `in_ready`. `sync_pat` must be held steady while a preamble or fill pattern is on the line.
- R11: A frame starts only for a byte that has `in_sof` high. A valid byte without `in_sof` between frames leaves the line idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable; one pulse per serial bit |
| enable | input | 1 | Transmitter enable, sampled at boundaries |
| fill_sync | input | 1 | Fill between frames: 0 idle ones, 1 repeated sync |
| sync_len | input | 2 | Preamble length select: 00 none, 01 quarter, 10 half, 11 full width |
| sync_pat | input | SYNC_W (16) | Sync pattern register contents |
| in_data | input | DATA_W (8) | Frame data byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte request window; a byte is taken on the next enabled bit |
| txd | output | 1 | Serial data out |
| rts | output | 1 | Request to send |

## Verification
The bench runs frames in both fill modes at every preamble length. For each frame it checks the whole bit stream, the bit where `rts` rises and the bit where it falls, against a stream it builds itself. A design that reads the pattern LSB first, selects the wrong slice, or leaves out the lead bit fails these stream comparisons. Mode, length and enable are changed in the middle of a frame and in the middle of a fill pattern, which catches a design that samples them live and cuts or stretches the bits already on the line. Further tests cover back-to-back bytes, an underrun, a valid byte that has no start marker, and a divided bit clock. These catch a byte request that comes a bit late, a frame that keeps going after its source runs dry, and state that moves between bit-clock enables.

// File: rtl/sfr_tx_pkg.sv
package sfr_tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_PRE  = 2'd2,
      ST_DATA = 2'd3
   } sfr_state_e;

   localparam logic [1:0] LEN_NONE    = 2'b00;
   localparam logic [1:0] LEN_QUARTER = 2'b01;
   localparam logic [1:0] LEN_HALF    = 2'b10;
   localparam logic [1:0] LEN_FULL    = 2'b11;

endpackage

// File: rtl/sfr_len_decode.sv
module sfr_len_decode
   import sfr_tx_pkg::*;
#(
   parameter int SYNC_W = 16,
   parameter int CNT_W  = 4
) (
   input  logic [1:0]       sel_i,
   output logic             has_pre_o,
   output logic [CNT_W-1:0] last_idx_o
);
   localparam int QW = SYNC_W / 4;
   localparam int HW = SYNC_W / 2;

   always_comb begin
      has_pre_o  = 1'b1;
      last_idx_o = '0;
      unique case (sel_i)
         LEN_QUARTER: last_idx_o = CNT_W'(QW - 1);
         LEN_HALF:    last_idx_o = CNT_W'(HW - 1);
         LEN_FULL:    last_idx_o = CNT_W'(SYNC_W - 1);
         default:     has_pre_o  = 1'b0;
      endcase
   end
endmodule

// File: rtl/sfr_pat_bit.sv
module sfr_pat_bit #(
   parameter int SYNC_W = 16,
   parameter int CNT_W  = 4
) (
   input  logic [SYNC_W-1:0] pat_i,
   input  logic [CNT_W-1:0]  idx_i,
   output logic              bit_o
);
   localparam int  IDX_W = (SYNC_W > 1) ? $clog2(SYNC_W) : 1;
   localparam bit  POW2  = ((SYNC_W & (SYNC_W - 1)) == 0);

   generate
      if (POW2) begin : g_direct
         assign bit_o = pat_i[idx_i[IDX_W-1:0]];
      end else begin : g_search
         always_comb begin
            bit_o = 1'b1;
            for (int k = 0; k < SYNC_W; k++) begin
               if (idx_i == CNT_W'(k)) bit_o = pat_i[k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sfr_data_shift.sv
module sfr_data_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic [DATA_W-1:0] din_i,
   output logic              msb_o
);
   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (load_i)  sh_q <= din_i;
      else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
   end

   assign msb_o = sh_q[DATA_W-1];
endmodule

// File: rtl/sfr_tx_framer.sv
module sfr_tx_framer
   import sfr_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SYNC_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              enable,
   input  logic              fill_sync,
   input  logic [1:0]        sync_len,
   input  logic [SYNC_W-1:0] sync_pat,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_last,
   output logic              in_ready,
   output logic              txd,
   output logic              rts
);
   localparam int MAXW  = (SYNC_W > DATA_W) ? SYNC_W : DATA_W;
   localparam int CNT_W = $clog2(MAXW);
   localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("sfr_tx_framer: DATA_W must be at least 2");
      end
      if (SYNC_W < 4 || (SYNC_W % 4) != 0) begin : g_bad_sync
         $error("sfr_tx_framer: SYNC_W must be a multiple of 4");
      end
   endgenerate

   sfr_state_e       st_q, st_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [CNT_W-1:0] idx_q, idx_n;
   logic             frm_q, frm_n;
   logic             mode_q, mode_n;
   logic             en_q, en_n;
   logic             pre_q, pre_n;
   logic             last_q, last_n;
   logic             load, shift, bnd, from_frame, start;
   logic             has_pre_new;
   logic [CNT_W-1:0] idx_new;
   logic             pat_bit, data_bit;

   sfr_len_decode #(.SYNC_W(SYNC_W), .CNT_W(CNT_W)) u_len (
      .sel_i      (sync_len),
      .has_pre_o  (has_pre_new),
      .last_idx_o (idx_new)
   );

   sfr_pat_bit #(.SYNC_W(SYNC_W), .CNT_W(CNT_W)) u_pat (
      .pat_i (sync_pat),
      .idx_i (cnt_q),
      .bit_o (pat_bit)
   );

   sfr_data_shift #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .shift_i (shift),
      .din_i   (in_data),
      .msb_o   (data_bit)
   );

   assign start = in_valid && in_sof;

   always_comb begin
      st_n       = st_q;
      cnt_n      = cnt_q;
      idx_n      = idx_q;
      frm_n      = frm_q;
      mode_n     = mode_q;
      en_n       = en_q;
      pre_n      = pre_q;
      last_n     = last_q;
      load       = 1'b0;
      shift      = 1'b0;
      bnd        = 1'b0;
      from_frame = 1'b0;
      if (bit_en) begin
         unique case (st_q)
            ST_IDLE: bnd = 1'b1;
            ST_LEAD: begin
               if (pre_q) begin
                  st_n  = ST_PRE;
                  frm_n = 1'b1;
                  cnt_n = idx_q;
               end else if (in_valid) begin
                  load   = 1'b1;
                  st_n   = ST_DATA;
                  cnt_n  = BYTE_LAST;
                  last_n = in_last;
               end else begin
                  bnd        = 1'b1;
                  from_frame = 1'b1;
               end
            end
            ST_PRE: begin
               if (cnt_q != '0) begin
                  cnt_n = cnt_q - 1'b1;
               end else if (frm_q && in_valid) begin
                  load   = 1'b1;
                  st_n   = ST_DATA;
                  cnt_n  = BYTE_LAST;
                  last_n = in_last;
               end else begin
                  bnd        = 1'b1;
                  from_frame = frm_q;
               end
            end
            default: begin
               if (cnt_q != '0) begin
                  cnt_n = cnt_q - 1'b1;
                  shift = 1'b1;
               end else if (!last_q && in_valid) begin
                  load   = 1'b1;
                  cnt_n  = BYTE_LAST;
                  last_n = in_last;
               end else begin
                  bnd        = 1'b1;
                  from_frame = 1'b1;
               end
            end
         endcase
         if (bnd) begin
            mode_n = fill_sync;
            en_n   = enable;
            pre_n  = has_pre_new;
            idx_n  = idx_new;
            frm_n  = 1'b0;
            if (!enable || (from_frame && !fill_sync)) begin
               st_n = ST_IDLE;
            end else if (fill_sync && has_pre_new) begin
               st_n  = ST_PRE;
               frm_n = start;
               cnt_n = idx_new;
            end else if (start) begin
               st_n = ST_LEAD;
            end else begin
               st_n = ST_IDLE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         idx_q  <= '0;
         frm_q  <= 1'b0;
         mode_q <= 1'b0;
         en_q   <= 1'b0;
         pre_q  <= 1'b0;
         last_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         cnt_q  <= cnt_n;
         idx_q  <= idx_n;
         frm_q  <= frm_n;
         mode_q <= mode_n;
         en_q   <= en_n;
         pre_q  <= pre_n;
         last_q <= last_n;
      end
   end

   always_comb begin
      unique case (st_q)
         ST_PRE:  txd = pat_bit;
         ST_DATA: txd = data_bit;
         default: txd = 1'b1;
      endcase
   end

   assign rts      = (st_q != ST_IDLE) || (mode_q && en_q);
   assign in_ready = ((st_q == ST_LEAD) && !pre_q)
                  || ((st_q == ST_PRE) && frm_q && (cnt_q == '0))
                  || ((st_q == ST_DATA) && (cnt_q == '0) && !last_q);
endmodule

// File: rtl/sfr_tx_checker.sv
module sfr_tx_checker (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic in_valid,
   input logic in_ready,
   input logic txd,
   input logic rts,
   input logic mode_q
);
   // R10: outputs only move on an enabled bit
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(txd) && $stable(rts) && $stable(in_ready)));

   // R4: a byte request lasts one bit and is followed by a non-request bit
   p_ready_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && in_ready && in_valid) |=> !in_ready);

   // R5: an underrun closes the frame, no second request follows
   p_underrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && in_ready && !in_valid) |=> !in_ready);

   // R4: requests only occur inside a frame, where rts is high
   p_ready_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> rts);

   // R6: with rts low the line idles at 1
   p_idle_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rts |-> txd);

   // R6: in idle-fill mode rts rises on a lead bit of 1
   p_lead_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rts) && !mode_q) |-> txd);
endmodule

bind sfr_tx_framer sfr_tx_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_en   (bit_en),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .txd      (txd),
   .rts      (rts),
   .mode_q   (mode_q)
);

// File: tb/sim_sfr_tx_framer.sv
`timescale 1ns/1ps
module sim_sfr_tx_framer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bit_en, enable, fill_sync;
   logic [1:0]  sync_len;
   logic [15:0] sync_pat;
   logic [7:0]  in_data;
   logic        in_valid, in_sof, in_last;
   logic        in_ready, txd, rts;

   int checks = 0;
   int errors = 0;
   int div = 1;
   int stepno = 0;
   bit hold_bad = 1'b0;
   bit done = 1'b0;
   logic s_txd, s_rts, s_rdy;

   always #2.5 clk = ~clk;

   sfr_tx_framer #(.DATA_W(8), .SYNC_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .enable(enable),
      .fill_sync(fill_sync), .sync_len(sync_len), .sync_pat(sync_pat),
      .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof),
      .in_last(in_last), .in_ready(in_ready), .txd(txd), .rts(rts)
   );

   // {fill mode, sync_len, sync_pat, data}
   localparam logic [26:0] VEC [8] = '{
      {1'b0, 2'b01, 16'h000A, 8'hA5},
      {1'b0, 2'b10, 16'h00C3, 8'h3C},
      {1'b0, 2'b11, 16'hB4E1, 8'h81},
      {1'b0, 2'b00, 16'hFFFF, 8'h5A},
      {1'b1, 2'b10, 16'h0096, 8'hE7},
      {1'b1, 2'b11, 16'h2D7C, 8'h0F},
      {1'b1, 2'b00, 16'h0000, 8'h99},
      {1'b1, 2'b01, 16'h0005, 8'h6C}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step();
      logic f_t, f_r, f_y;
      f_t = 1'b0; f_r = 1'b0; f_y = 1'b0;
      for (int k = 0; k < div; k++) begin
         @(negedge clk);
         if (k == 0) begin
            f_t = txd; f_r = rts; f_y = in_ready;
         end else if (txd !== f_t || rts !== f_r || in_ready !== f_y) begin
            hold_bad = 1'b1;
         end
         bit_en = (k == div - 1);
      end
      s_txd = txd; s_rts = rts; s_rdy = in_ready;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_en = 1'b1; enable = 1'b0; fill_sync = 1'b0;
      sync_len = 2'b00; sync_pat = '0; in_data = '0;
      in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0; div = 1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_steps(input int n, input logic [63:0] et,
                            input logic [63:0] er, input logic [63:0] rm,
                            input string req);
      logic [63:0] at, ar, ay;
      at = '0; ar = '0; ay = '0; hold_bad = 1'b0;
      for (int j = 1; j <= n; j++) begin
         step();
         at[n-j] = s_txd; ar[n-j] = s_rts; ay[n-j] = s_rdy;
         stepno = j;
      end
      check(at === et, req, "txd stream", at, et);
      check(ar === er, req, "rts stream", ar, er);
      check(ay === rm, "R4", "in_ready windows", ay, rm);
      if (div > 1) check(!hold_bad, "R10", "output moved between bit enables", 64'(hold_bad), 64'd0);
   endtask

   task automatic run_frame(input logic m, input logic [1:0] len,
                            input logic [15:0] pat, input logic [7:0] data,
                            input int d, input int tweak, input string req);
      int p, lead, jacc, n, idx, a;
      logic [63:0] et, er, rm;
      p    = (len == 2'b01) ? 4 : (len == 2'b10) ? 8 : (len == 2'b11) ? 16 : 0;
      lead = (!m || len == 2'b00) ? 1 : 0;
      jacc = p + lead;
      n    = lead + p + 10;
      et = '0; er = '0; rm = '0;
      for (int j = 1; j <= n; j++) begin
         idx = j - lead;
         if (lead == 1 && j == 1)   et[n-j] = 1'b1;
         else if (idx <= p)         et[n-j] = pat[p-idx];
         else if (idx <= p + 8)     et[n-j] = data[8-(idx-p)];
         else begin
            a = idx - p - 8;
            et[n-j] = (m && p > 0) ? pat[p-a] : 1'b1;
         end
         er[n-j] = (idx <= p + 8) ? 1'b1 : m;
      end
      rm[n-jacc] = 1'b1;
      do_reset();
      div = d;
      step();
      enable = 1'b1; fill_sync = m; sync_len = len; sync_pat = pat;
      in_data = data; in_valid = 1'b1; in_sof = 1'b1; in_last = 1'b1;
      stepno = 0;
      fork
         run_steps(n, et, er, rm, req);
         begin
            wait (stepno == jacc + 1);
            in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
         end
         begin
            if (tweak == 1) begin
               wait (stepno == 3);
               enable = 1'b0;
            end
         end
      join
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] rm;
      // R1: reset state
      do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      check(txd === 1'b1, "R1", "txd in reset", 64'(txd), 64'd1);
      check(rts === 1'b0, "R1", "rts in reset", 64'(rts), 64'd0);
      check(in_ready === 1'b0, "R1", "in_ready in reset", 64'(in_ready), 64'd0);
      rst_n = 1'b1;
      step();
      check({txd, rts, in_ready} === 3'b100, "R1", "outputs after reset",
            64'({txd, rts, in_ready}), 64'b100);

      // table of single-byte frames
      for (int v = 0; v < 8; v++) begin
         run_frame(VEC[v][26], VEC[v][25:24], VEC[v][23:8], VEC[v][7:0], 1, 0,
                   VEC[v][26] ? "R2 R7" : "R2 R6");
      end

      // R3 / R4: two bytes back to back
      do_reset(); step();
      enable = 1'b1; sync_len = 2'b01; sync_pat = 16'h000A;
      in_data = 8'hC6; in_valid = 1'b1; in_sof = 1'b1; in_last = 1'b0;
      stepno = 0;
      rm = '0; rm[23-5] = 1'b1; rm[23-13] = 1'b1;
      fork
         run_steps(23, 64'({1'b1, 4'hA, 8'hC6, 8'h1B, 2'b11}),
                   64'({21'h1FFFFF, 2'b00}), rm, "R3");
         begin
            wait (stepno == 6);
            in_data = 8'h1B; in_sof = 1'b0; in_last = 1'b1;
            wait (stepno == 14);
            in_valid = 1'b0;
         end
      join

      // R5: underrun after the first byte
      do_reset(); step();
      enable = 1'b1; sync_len = 2'b10; sync_pat = 16'h0055;
      in_data = 8'hF0; in_valid = 1'b1; in_sof = 1'b1; in_last = 1'b0;
      stepno = 0;
      rm = '0; rm[20-9] = 1'b1; rm[20-17] = 1'b1;
      fork
         run_steps(20, 64'({1'b1, 8'h55, 8'hF0, 3'b111}),
                   64'({17'h1FFFF, 3'b000}), rm, "R5");
         begin
            wait (stepno == 10);
            in_valid = 1'b0; in_sof = 1'b0;
         end
      join

      // R8: mode and length changed inside a frame take effect after it
      do_reset(); step();
      enable = 1'b1; sync_len = 2'b01; sync_pat = 16'h0009;
      in_data = 8'h3A; in_valid = 1'b1; in_sof = 1'b1; in_last = 1'b1;
      stepno = 0;
      rm = '0; rm[29-5] = 1'b1;
      fork
         run_steps(29, 64'({1'b1, 4'h9, 8'h3A, 16'h0009}),
                   64'({29{1'b1}}), rm, "R8");
         begin
            wait (stepno == 3);
            fill_sync = 1'b1; sync_len = 2'b11;
            wait (stepno == 6);
            in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
         end
      join

      // R7: repeated sync fill with rts held
      do_reset(); step();
      enable = 1'b1; fill_sync = 1'b1; sync_len = 2'b01; sync_pat = 16'h0006;
      run_steps(12, 64'(12'h666), 64'(12'hFFF), 64'd0, "R7");

      // R8: fill mode dropped inside a fill pattern
      do_reset(); step();
      enable = 1'b1; fill_sync = 1'b1; sync_len = 2'b10; sync_pat = 16'h00A7;
      stepno = 0;
      fork
         run_steps(10, 64'({8'hA7, 2'b11}), 64'({8'hFF, 2'b00}), 64'd0, "R8");
         begin
            wait (stepno == 2);
            fill_sync = 1'b0;
         end
      join

      // R8: enable dropped inside a frame, frame completes
      run_frame(1'b0, 2'b01, 16'h000F, 8'h00, 1, 1, "R8");

      // R9: disabled block ignores a frame start
      do_reset(); step();
      sync_len = 2'b01; sync_pat = 16'h0003;
      in_data = 8'h42; in_valid = 1'b1; in_sof = 1'b1; in_last = 1'b1;
      run_steps(5, 64'(5'h1F), 64'd0, 64'd0, "R9");

      // R11: valid byte without start marker leaves the line idle
      enable = 1'b1; in_sof = 1'b0;
      run_steps(5, 64'(5'h1F), 64'd0, 64'd0, "R11");

      // R10: divided bit clock
      run_frame(1'b0, 2'b01, 16'h0006, 8'hC3, 3, 0, "R10");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule